// File: doc/BRIEF.md
# Multi-Source Reset Pulse Generator

This block produces one active-low, open-drain style reset for a system. Three sources can start it: a power-fail indication from an external supply monitor, a fast reset request, and a slow reset request. Each request starts a reset only when it stays low for at least its own minimum width. Shorter glitches are ignored. Once a source has qualified, the reset is asserted. It is held until every source has gone away and its recovery or release period has run out. The reset is then let go.

The output is never driven high. The port `rst_oe_o` is the enable of an external pull-down: 1 means "pull the reset line low" and 0 means "leave it floating". All three inputs are asynchronous. Each is brought into the reference clock domain through a synchronizer before it is used. Every timing window is a parameter given in reference-clock ticks. The same logic therefore covers a nanosecond-scale window on the fast request and a multi-millisecond window on the slow one.

Top module: `rst_pulse_gen`

## Requirements
- R1: While `arst_ni` is low, `rst_oe_o` is 0 at once. After reset, with `pwr_fail_i` low and both request inputs high, `rst_oe_o` stays 0.
- R2: `pwr_fail_i` is active high and needs no minimum width. `rst_oe_o` rises on the third clock edge after `pwr_fail_i` rises. It stays 1 while `pwr_fail_i` is high. It falls on edge PF_REC_TICKS+3 after `pwr_fail_i` falls.
- R3: If `req_fast_ni` (active low, idle high) is low for FAST_QUAL_TICKS or more consecutive clock samples, a reset starts. `rst_oe_o` rises on edge FAST_QUAL_TICKS+3 after the fall. A low pulse of FAST_QUAL_TICKS-1 samples or fewer leaves `rst_oe_o` at 0.
- R4: If `req_slow_ni` (active low, idle high) is low for SLOW_QUAL_TICKS or more consecutive samples, a reset starts in the same way. A low pulse of SLOW_QUAL_TICKS-1 samples or fewer leaves `rst_oe_o` at 0.
- R5: After a qualified request input returns high, `rst_oe_o` falls on edge REQ_REL_TICKS+4 after the rise. A qualified low pulse of N samples therefore gives N-QUAL+REQ_REL_TICKS+1 cycles with `rst_oe_o` at 1.
- R6: Low time on a request input does not add up across pulses. One high sample between two sub-window low pulses clears the count, and neither pulse starts a reset.
- R7: When sources overlap, `rst_oe_o` stays at 1 without a gap. It is released only after every source is inactive and every recovery or release period has run out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock |
| arst_ni | input | 1 | Asynchronous active-low reset of the block's registers |
| pwr_fail_i | input | 1 | Power-fail indication from the supply monitor, active high |
| req_fast_ni | input | 1 | Fast reset request, active low, idles high |
| req_slow_ni | input | 1 | Slow reset request, active low, idles high |
| rst_oe_o | output | 1 | Pull-down enable for the open-drain reset: 1 drives the line low, 0 leaves it floating |

## Verification
The bound checker watches some relations on every cycle:
- any busy source or running timer forces the output on the next cycle;
- the output never drops while a source was still busy;
- a synchronized power-fail always asserts the output;
- neither request qualifier fires before its synchronized input has been low for a full window.

Other behaviour only the bench's scenarios can show. These are the exact cycle counts of assertion and release, the rejection one sample below each window and acceptance at the window, and the failure of split glitches to add up. They also include the gap-free joining of overlapping sources.

// File: rtl/rpg_pkg.sv
package rpg_pkg;
   localparam int N_REQ = 2;
   localparam int N_SRC = N_REQ + 1;
   localparam int CHK_RUN_W = 16;
   typedef enum logic [1:0] {
      SRC_PWR  = 2'd0,
      SRC_FAST = 2'd1,
      SRC_SLOW = 2'd2
   } rpg_src_e;
endpackage

// File: rtl/rpg_sync.sv
module rpg_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk_i,
   input  logic arst_ni,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] shift_q;

   always_ff @(posedge clk_i or negedge arst_ni) begin
      if (!arst_ni) shift_q <= {STAGES{RST_VAL}};
      else          shift_q <= {shift_q[STAGES-2:0], d_i};
   end

   assign q_o = shift_q[STAGES-1];
endmodule

// File: rtl/rpg_qual.sv
module rpg_qual #(
   parameter int QUAL_TICKS = 4
) (
   input  logic clk_i,
   input  logic arst_ni,
   input  logic act_i,
   output logic qual_o
);
   localparam int W = $clog2(QUAL_TICKS + 1);
   localparam logic [W-1:0] LIMIT = W'(QUAL_TICKS);

   logic [W-1:0] run_q;

   always_ff @(posedge clk_i or negedge arst_ni) begin
      if (!arst_ni)            run_q <= '0;
      else if (!act_i)         run_q <= '0;
      else if (run_q != LIMIT) run_q <= run_q + W'(1);
   end

   assign qual_o = (run_q == LIMIT);
endmodule

// File: rtl/rpg_hold.sv
module rpg_hold #(
   parameter int HOLD_TICKS = 24
) (
   input  logic clk_i,
   input  logic arst_ni,
   input  logic act_i,
   output logic busy_o
);
   localparam int W = $clog2(HOLD_TICKS + 1);

   logic [W-1:0] left_q;

   always_ff @(posedge clk_i or negedge arst_ni) begin
      if (!arst_ni)          left_q <= '0;
      else if (act_i)        left_q <= W'(HOLD_TICKS);
      else if (left_q != '0) left_q <= left_q - W'(1);
   end

   assign busy_o = act_i | (left_q != '0);
endmodule

// File: rtl/rst_pulse_gen.sv
module rst_pulse_gen #(
   parameter int SYNC_STAGES     = 2,
   parameter int FAST_QUAL_TICKS = 4,
   parameter int SLOW_QUAL_TICKS = 40,
   parameter int REQ_REL_TICKS   = 24,
   parameter int PF_REC_TICKS    = 32
) (
   input  logic clk_i,
   input  logic arst_ni,
   input  logic pwr_fail_i,
   input  logic req_fast_ni,
   input  logic req_slow_ni,
   output logic rst_oe_o
);
   import rpg_pkg::*;

   // elaboration-time parameter checks
   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (FAST_QUAL_TICKS < 1 || SLOW_QUAL_TICKS < 1) begin : g_chk_qual
      $error("qualification windows must be at least one tick");
   end
   if (FAST_QUAL_TICKS >= SLOW_QUAL_TICKS) begin : g_chk_order
      $error("fast window must be shorter than slow window");
   end
   if (REQ_REL_TICKS < 1 || PF_REC_TICKS < 1) begin : g_chk_hold
      $error("hold periods must be at least one tick");
   end

   logic [N_REQ-1:0] req_n_raw;
   logic [N_REQ-1:0] req_act;
   logic [N_REQ-1:0] qual_vec;
   logic [N_SRC-1:0] busy_vec;
   logic             pf_act;
   logic             oe_q;

   assign req_n_raw = {req_slow_ni, req_fast_ni};

   // power-fail path: synchronize, no width filter, recovery stretch
   rpg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pf_sync (
      .clk_i(clk_i), .arst_ni(arst_ni), .d_i(pwr_fail_i), .q_o(pf_act)
   );
   rpg_hold #(.HOLD_TICKS(PF_REC_TICKS)) u_pf_hold (
      .clk_i(clk_i), .arst_ni(arst_ni), .act_i(pf_act),
      .busy_o(busy_vec[SRC_PWR])
   );

   // request paths: synchronize, width filter, release stretch
   for (genvar g = 0; g < N_REQ; g++) begin : g_req
      localparam int QUAL = (g == 0) ? FAST_QUAL_TICKS : SLOW_QUAL_TICKS;
      logic req_q;

      rpg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
         .clk_i(clk_i), .arst_ni(arst_ni), .d_i(req_n_raw[g]), .q_o(req_q)
      );
      assign req_act[g] = ~req_q;

      rpg_qual #(.QUAL_TICKS(QUAL)) u_qual (
         .clk_i(clk_i), .arst_ni(arst_ni), .act_i(req_act[g]),
         .qual_o(qual_vec[g])
      );
      rpg_hold #(.HOLD_TICKS(REQ_REL_TICKS)) u_hold (
         .clk_i(clk_i), .arst_ni(arst_ni), .act_i(qual_vec[g]),
         .busy_o(busy_vec[g+1])
      );
   end

   always_ff @(posedge clk_i or negedge arst_ni) begin
      if (!arst_ni) oe_q <= 1'b0;
      else          oe_q <= |busy_vec;
   end

   assign rst_oe_o = oe_q;
endmodule

// File: rtl/rpg_chk.sv
module rpg_chk #(
   parameter int FAST_QUAL = 4,
   parameter int SLOW_QUAL = 40
) (
   input logic       clk,
   input logic       arst_n,
   input logic       rst_oe,
   input logic       pf_act,
   input logic [1:0] req_act,
   input logic [1:0] qual,
   input logic [2:0] busy
);
   import rpg_pkg::*;

   logic [CHK_RUN_W-1:0] run_fast, run_slow;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         run_fast <= '0;
         run_slow <= '0;
      end else begin
         if (!req_act[0])     run_fast <= '0;
         else if (&run_fast == 1'b0) run_fast <= run_fast + 1'b1;
         if (!req_act[1])     run_slow <= '0;
         else if (&run_slow == 1'b0) run_slow <= run_slow + 1'b1;
      end
   end

   p_pf_asserts_r2: assert property (@(posedge clk) disable iff (!arst_n)
      pf_act |=> rst_oe);

   p_fast_window_r3: assert property (@(posedge clk) disable iff (!arst_n)
      $rose(qual[0]) |-> (run_fast >= CHK_RUN_W'(FAST_QUAL)));

   p_slow_window_r4: assert property (@(posedge clk) disable iff (!arst_n)
      $rose(qual[1]) |-> (run_slow >= CHK_RUN_W'(SLOW_QUAL)));

   p_busy_holds_r7: assert property (@(posedge clk) disable iff (!arst_n)
      (|busy) |=> rst_oe);

   p_release_idle_r7: assert property (@(posedge clk) disable iff (!arst_n)
      $fell(rst_oe) |-> ($past(busy) == 3'b000));
endmodule

bind rst_pulse_gen rpg_chk #(
   .FAST_QUAL(FAST_QUAL_TICKS),
   .SLOW_QUAL(SLOW_QUAL_TICKS)
) u_chk (
   .clk(clk_i),
   .arst_n(arst_ni),
   .rst_oe(rst_oe_o),
   .pf_act(pf_act),
   .req_act(req_act),
   .qual(qual_vec),
   .busy(busy_vec)
);

// File: tb/rst_pulse_gen_tb.sv
module rst_pulse_gen_tb_top;
   localparam int FQ  = 4;
   localparam int SQ  = 40;
   localparam int REL = 24;
   localparam int REC = 32;
   localparam int SPAN_PAD = 100 + REL + REC;

   typedef struct packed {
      logic [1:0]  src;
      logic [31:0] len;
      logic [31:0] highs;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VECS [NV] = '{
      '{2'd1, 32'(FQ-1), 32'd0},
      '{2'd1, 32'(FQ),   32'(REL+1)},
      '{2'd1, 32'(FQ+5), 32'(REL+6)},
      '{2'd1, 32'd1,     32'd0},
      '{2'd2, 32'(SQ-1), 32'd0},
      '{2'd2, 32'(SQ),   32'(REL+1)},
      '{2'd2, 32'(SQ+3), 32'(REL+4)},
      '{2'd2, 32'(FQ),   32'd0},
      '{2'd0, 32'd1,     32'(1+REC)},
      '{2'd0, 32'd10,    32'(10+REC)},
      '{2'd0, 32'd3,     32'(3+REC)}
   };

   logic clk = 1'b0;
   logic arst_n = 1'b0;
   logic pwr_fail = 1'b0;
   logic req_fast_n = 1'b1;
   logic req_slow_n = 1'b1;
   logic rst_oe;

   int checks = 0;
   int fails = 0;

   always #4 clk = ~clk;

   rst_pulse_gen #(
      .SYNC_STAGES(2), .FAST_QUAL_TICKS(FQ), .SLOW_QUAL_TICKS(SQ),
      .REQ_REL_TICKS(REL), .PF_REC_TICKS(REC)
   ) dut_i (
      .clk_i(clk), .arst_ni(arst_n), .pwr_fail_i(pwr_fail),
      .req_fast_ni(req_fast_n), .req_slow_ni(req_slow_n), .rst_oe_o(rst_oe)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic drive(input int src, input bit on);
      case (src)
         0:       pwr_fail   = on;
         1:       req_fast_n = ~on;
         default: req_slow_n = ~on;
      endcase
   endtask

   task automatic pulse(input int src, input int len, input int span,
                        output int highs, output int rise_at, output int fall_at);
      highs = 0; rise_at = 0; fall_at = 0;
      @(negedge clk);
      drive(src, 1'b1);
      for (int j = 1; j <= span; j++) begin
         @(negedge clk);
         if (rst_oe) begin
            highs++;
            if (rise_at == 0) rise_at = j;
         end else if (rise_at != 0 && fall_at == 0) begin
            fall_at = j;
         end
         if (j == len) drive(src, 1'b0);
      end
   endtask

   task automatic summary;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      int h, r, f;
      repeat (3) @(negedge clk);
      chk("R1 oe during reset", int'(rst_oe), 0);
      arst_n = 1'b1;
      repeat (10) @(negedge clk);
      chk("R1 oe idle after reset", int'(rst_oe), 0);

      // table walk: single-source pulses
      for (int i = 0; i < NV; i++) begin
         pulse(int'(VECS[i].src), int'(VECS[i].len),
               int'(VECS[i].len) + SPAN_PAD, h, r, f);
         case (VECS[i].src)
            2'd0:    chk("R2 pwr-fail high cycles", h, int'(VECS[i].highs));
            2'd1:    chk("R3/R5 fast high cycles", h, int'(VECS[i].highs));
            default: chk("R4/R5 slow high cycles", h, int'(VECS[i].highs));
         endcase
      end

      // latency and release edges
      pulse(1, FQ + 2, FQ + 2 + SPAN_PAD, h, r, f);
      chk("R3 fast assert edge", r, FQ + 3);
      chk("R5 fast release edge", f - (FQ + 2), REL + 4);
      pulse(2, SQ, SQ + SPAN_PAD, h, r, f);
      chk("R4 slow assert edge", r, SQ + 3);
      chk("R5 slow release edge", f - SQ, REL + 4);
      pulse(0, 6, 6 + SPAN_PAD, h, r, f);
      chk("R2 pwr-fail assert edge", r, 3);
      chk("R2 pwr-fail release edge", f - 6, REC + 3);

      // R6: two sub-window pulses split by one high sample
      h = 0;
      @(negedge clk);
      req_fast_n = 1'b0;
      for (int j = 1; j <= 2 * FQ + SPAN_PAD; j++) begin
         @(negedge clk);
         if (rst_oe) h++;
         if (j == FQ - 1) req_fast_n = 1'b1;
         if (j == FQ)     req_fast_n = 1'b0;
         if (j == 2 * FQ - 1) req_fast_n = 1'b1;
      end
      chk("R6 split glitches ignored", h, 0);

      // R7: power-fail overlapped by a slow request, no gap expected
      h = 0; r = 0; f = 0;
      @(negedge clk);
      pwr_fail = 1'b1;
      req_slow_n = 1'b0;
      for (int j = 1; j <= SQ + SPAN_PAD; j++) begin
         @(negedge clk);
         if (rst_oe) begin
            h++;
            if (r == 0) r = j;
         end else if (r != 0 && f == 0) f = j;
         if (j == 20) pwr_fail = 1'b0;
         if (j == SQ) req_slow_n = 1'b1;
      end
      chk("R7 overlap high cycles", h, SQ + REL + 1);
      chk("R7 overlap release edge", f, SQ + REL + 4);

      // R1: asynchronous reset while asserted
      @(negedge clk);
      pwr_fail = 1'b1;
      repeat (6) @(negedge clk);
      chk("R1 oe before mid reset", int'(rst_oe), 1);
      arst_n = 1'b0;
      #1;
      chk("R1 oe cleared by reset", int'(rst_oe), 0);
      pwr_fail = 1'b0;
      @(negedge clk);
      arst_n = 1'b1;
      repeat (8) @(negedge clk);
      chk("R1 oe idle after mid reset", int'(rst_oe), 0);

      summary();
      $finish;
   end
endmodule